// File: doc/BRIEF.md
# ATA Task-File Register Block

This block is the device side of an ATA-style task-file register set on a byte-wide host bus. The host writes the sector number, cylinder low, cylinder high and drive/head registers by offset. From them the block produces either a 28-bit logical block address or a cylinder/head/sector triple, depending on the mode bit in the drive/head register. A write to offset 7h hands a command byte to the device core.

The device core supplies busy, ready and six further status flags, and raises interrupt events. The block returns these as the Status byte at offset 7h and the Alternate Status byte at offset Eh. It holds a sticky interrupt request that a Status read clears and an Alternate Status read does not. A configuration input gives the device's own drive number. The drive bit of the drive/head register must match it before the device accepts commands or answers status reads.

Read data is registered and appears one cycle after the read strobe. Writes take effect at the clock edge that samples them.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, the sector number, cylinder low and cylinder high registers read 00h. The drive/head register reads A0h. The interrupt request is 0, the command strobe is 0 and read data is 00h.
- R2: Offsets 3h (sector number), 4h (cylinder low), 5h (cylinder high) and 6h (drive/head) are written and read back byte-wide. Bits 7 and 5 of the drive/head register always read as 1. Read data appears on the cycle after the read strobe.
- R3: When drive/head bit 6 is 1 (LBA mode), the block sets lba_mode to 1. It outputs the address as {drive/head[3:0], cylinder high, cylinder low, sector number} on lba_addr, and drives the CHS outputs as 0.
- R4: When drive/head bit 6 is 0 (CHS mode), the block sets lba_mode to 0. It outputs head = drive/head[3:0], cylinder = {cylinder high, cylinder low} and sector = sector number, and drives lba_addr as 0.
- R5: drv_sel equals drive/head bit 4. drv_match is 1 exactly when drv_sel equals cfg_drive.
- R6: With drv_match = 1, a read of offset 7h or Eh returns 80h while core_busy is 1. Otherwise it returns {0, core_ready, core_flags[5:0]}.
- R7: While core_busy is 1, host writes to offsets 3h to 7h leave every register unchanged and raise no command strobe.
- R8: A write to offset 7h with core_busy = 0 and drv_match = 1 raises cmd_valid for exactly one cycle, on the cycle after the write, with cmd_byte equal to the written byte.
- R9: irq goes to 1 on the cycle after a core_irq_evt pulse. A matched read of offset 7h clears it. A read of offset Eh leaves it set. When an event and a clearing read fall in the same cycle, irq stays 1.
- R10: With drv_match = 0, reads of offsets 7h and Eh return 00h and do not clear irq, and writes to offset 7h raise no command strobe. Writes to offsets 3h to 6h are still accepted.
- R11: Reads of any other offset return 00h. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_drive | input | 1 | Configured drive number of this device |
| host_addr | input | 4 | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| core_busy | input | 1 | Device core busy |
| core_ready | input | 1 | Device core ready for a command |
| core_flags | input | 6 | Remaining status bits 5:0 |
| core_irq_evt | input | 1 | One-cycle interrupt event |
| irq | output | 1 | Sticky interrupt request |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte |
| lba_mode | output | 1 | 1 = logical block addressing |
| lba_addr | output | 28 | Logical block address (LBA mode) |
| chs_cyl | output | 16 | Cylinder (CHS mode) |
| chs_head | output | 4 | Head (CHS mode) |
| chs_sect | output | 8 | Sector (CHS mode) |
| drv_sel | output | 1 | Drive bit from drive/head |
| drv_match | output | 1 | Drive bit equals cfg_drive |

## Verification
The bench goes after the interrupt corner cases. It checks that a design clearing irq on the alternate read loses an interrupt, that one letting the clear win a simultaneous event drops an event, and that one clearing on a read addressed to the other drive steals that drive's interrupt. It writes while busy and checks that a design which ignores busy corrupts the address registers or issues a phantom command. It reads drive/head after random writes, so that a design which stores bits 7 and 5 returns a wrong value. It also switches modes, so that a design which leaves the other view's outputs live or swaps the byte order of the address is caught.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [3:0] OFF_SECT = 4'h3;
  localparam logic [3:0] OFF_CYLL = 4'h4;
  localparam logic [3:0] OFF_CYLH = 4'h5;
  localparam logic [3:0] OFF_DRVH = 4'h6;
  localparam logic [3:0] OFF_STAT = 4'h7;
  localparam logic [3:0] OFF_ALTS = 4'hE;

  localparam logic [7:0] DRVH_FIXED = 8'hA0;

  typedef struct packed {
    logic [7:0] sect;
    logic [7:0] cyl_lo;
    logic [7:0] cyl_hi;
    logic [7:0] drvh;
  } tf_regs_t;
endpackage

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile
  import ata_tf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  output tf_regs_t          regs
);
  tf_regs_t r_q;
  logic     wr_ok;

  assign wr_ok = wr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q.sect   <= '0;
      r_q.cyl_lo <= '0;
      r_q.cyl_hi <= '0;
      r_q.drvh   <= DRVH_FIXED;
    end else if (wr_ok) begin
      if (addr == ADDR_W'(OFF_SECT)) r_q.sect   <= wdata;
      if (addr == ADDR_W'(OFF_CYLL)) r_q.cyl_lo <= wdata;
      if (addr == ADDR_W'(OFF_CYLH)) r_q.cyl_hi <= wdata;
      if (addr == ADDR_W'(OFF_DRVH)) r_q.drvh   <= wdata | DRVH_FIXED;
    end
  end

  assign regs = r_q;

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busy) |=> $stable(r_q));

  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (r_q.drvh[7] && r_q.drvh[5]));
endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status #(
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              ready,
  input  logic [FLAG_W-1:0] flags,
  input  logic              irq_evt,
  input  logic              irq_clr,
  output logic [7:0]        stat_byte,
  output logic              irq
);
  logic irq_q;

  always_comb begin
    if (busy) stat_byte = 8'h80;
    else      stat_byte = {1'b0, ready, flags};
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (irq_evt) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    irq_evt |=> irq);

  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !irq_evt) |=> !irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_clr && !irq_evt) |=> (irq == $past(irq)));
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FLAG_W = 6,
  localparam int LBA_W = 28,
  localparam int CYL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_drive,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              core_busy,
  input  logic              core_ready,
  input  logic [FLAG_W-1:0] core_flags,
  input  logic              core_irq_evt,
  output logic              irq,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  output logic              lba_mode,
  output logic [LBA_W-1:0]  lba_addr,
  output logic [CYL_W-1:0]  chs_cyl,
  output logic [3:0]        chs_head,
  output logic [7:0]        chs_sect,
  output logic              drv_sel,
  output logic              drv_match
);
  tf_regs_t   regs;
  logic [7:0] stat_byte;
  logic       is_stat, is_alts, stat_clr, cmd_go;
  logic [7:0] rd_next;

  ata_tf_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (host_wr),
    .addr  (host_addr),
    .wdata (host_wdata),
    .busy  (core_busy),
    .regs  (regs)
  );

  assign drv_sel   = regs.drvh[4];
  assign drv_match = (drv_sel == cfg_drive);
  assign is_stat   = (host_addr == ADDR_W'(OFF_STAT));
  assign is_alts   = (host_addr == ADDR_W'(OFF_ALTS));
  assign stat_clr  = host_rd && is_stat && drv_match;
  assign cmd_go    = host_wr && is_stat && !core_busy && drv_match;

  ata_tf_status #(.FLAG_W(FLAG_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .busy      (core_busy),
    .ready     (core_ready),
    .flags     (core_flags),
    .irq_evt   (core_irq_evt),
    .irq_clr   (stat_clr),
    .stat_byte (stat_byte),
    .irq       (irq)
  );

  // address views
  assign lba_mode = regs.drvh[6];
  always_comb begin
    if (lba_mode) begin
      lba_addr = {regs.drvh[3:0], regs.cyl_hi, regs.cyl_lo, regs.sect};
      chs_cyl  = '0;
      chs_head = '0;
      chs_sect = '0;
    end else begin
      lba_addr = '0;
      chs_cyl  = {regs.cyl_hi, regs.cyl_lo};
      chs_head = regs.drvh[3:0];
      chs_sect = regs.sect;
    end
  end

  // read mux
  always_comb begin
    rd_next = 8'h00;
    if (host_addr == ADDR_W'(OFF_SECT))      rd_next = regs.sect;
    else if (host_addr == ADDR_W'(OFF_CYLL)) rd_next = regs.cyl_lo;
    else if (host_addr == ADDR_W'(OFF_CYLH)) rd_next = regs.cyl_hi;
    else if (host_addr == ADDR_W'(OFF_DRVH)) rd_next = regs.drvh;
    else if (is_stat || is_alts)             rd_next = drv_match ? stat_byte : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      cmd_valid  <= 1'b0;
      cmd_byte   <= '0;
    end else begin
      if (host_rd) host_rdata <= rd_next;
      cmd_valid <= cmd_go;
      if (cmd_go) cmd_byte <= host_wdata;
    end
  end

  // R8
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_go) |=> !cmd_valid);

  // R7
  cmd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && core_busy) |=> !cmd_valid);

  // R10
  cmd_match_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !drv_match) |=> !cmd_valid);

  // R6
  busy_read_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && (is_stat || is_alts) && drv_match && core_busy) |=> (host_rdata == 8'h80));

  // R10
  alt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && is_alts && irq) |=> irq);
endmodule

// File: tb/tb_ata_taskfile.sv
module tb_ata_taskfile;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1, cfg_drive = 0;
  logic [3:0]  host_addr = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_wdata = 0, host_rdata;
  logic        core_busy = 0, core_ready = 0, core_irq_evt = 0;
  logic [5:0]  core_flags = 0;
  logic        irq, cmd_valid, lba_mode, drv_sel, drv_match;
  logic [7:0]  cmd_byte, chs_sect;
  logic [27:0] lba_addr;
  logic [15:0] chs_cyl;
  logic [3:0]  chs_head;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m_sect = 0, m_cl = 0, m_ch = 0, m_dh = 8'hA0;
  logic m_irq = 0;

  ata_taskfile dut (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic mmatch();
    return m_dh[4] == cfg_drive;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h3: return m_sect;
      4'h4: return m_cl;
      4'h5: return m_ch;
      4'h6: return m_dh;
      4'h7, 4'hE: begin
        if (!mmatch()) return 8'h00;
        if (core_busy) return 8'h80;
        return {1'b0, core_ready, core_flags};
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_views();
    chk("R5 drv_sel", drv_sel, m_dh[4]);
    chk("R5 drv_match", drv_match, mmatch());
    chk("R3/R4 mode", lba_mode, m_dh[6]);
    if (m_dh[6]) begin
      chk("R3 lba", lba_addr, {m_dh[3:0], m_ch, m_cl, m_sect});
      chk("R3 chs zero", {chs_cyl, chs_head, chs_sect}, 0);
    end else begin
      chk("R4 cyl", chs_cyl, {m_ch, m_cl});
      chk("R4 head", chs_head, m_dh[3:0]);
      chk("R4 sect", chs_sect, m_sect);
      chk("R4 lba zero", lba_addr, 0);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    logic exp_cmd;
    host_addr = a; host_wdata = d; host_wr = 1;
    exp_cmd = (a == 4'h7) && !core_busy && mmatch();
    if (!core_busy) begin
      case (a)
        4'h3: m_sect = d;
        4'h4: m_cl = d;
        4'h5: m_ch = d;
        4'h6: m_dh = d | 8'hA0;
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    host_wr = 0;
    chk("R7/R8/R10 cmd_valid", cmd_valid, exp_cmd);
    if (exp_cmd) chk("R8 cmd_byte", cmd_byte, d);
    @(posedge clk); @(negedge clk);
    chk("R8 one-cycle", cmd_valid, 0);
  endtask

  task automatic do_rd(input logic [3:0] a, input string req);
    logic [7:0] e;
    host_addr = a; host_rd = 1;
    e = exp_rd(a);
    if (a == 4'h7 && mmatch() && !core_irq_evt) m_irq = 0;
    if (core_irq_evt) m_irq = 1;
    @(posedge clk); @(negedge clk);
    host_rd = 0; core_irq_evt = 0;
    chk(req, host_rdata, e);
    chk("R9 irq", irq, m_irq);
  endtask

  task automatic pulse_evt();
    core_irq_evt = 1;
    @(posedge clk); @(negedge clk);
    core_irq_evt = 0;
    m_irq = 1;
    chk("R9 irq set", irq, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 irq", irq, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 rdata", host_rdata, 0);
    do_rd(4'h3, "R1 sect");
    do_rd(4'h4, "R1 cyl_lo");
    do_rd(4'h5, "R1 cyl_hi");
    do_rd(4'h6, "R1 drvh A0");
    chk_views();
    do_rd(4'h7, "R1/R6 ready low");

    // R2 / R3 / R4 directed
    do_wr(4'h3, 8'h12); do_wr(4'h4, 8'h34); do_wr(4'h5, 8'h56);
    do_wr(4'h6, 8'h4B);
    do_rd(4'h6, "R2 drvh fixed bits");
    chk_views();
    do_wr(4'h6, 8'h05);
    chk_views();

    // R6 status
    core_ready = 1; core_flags = 6'h15;
    do_rd(4'h7, "R6 status");
    do_rd(4'hE, "R6 alt status");
    core_busy = 1;
    do_rd(4'hE, "R6 busy");
    // R7 busy writes ignored
    do_wr(4'h3, 8'hFF); do_wr(4'h6, 8'h1F); do_wr(4'h7, 8'hEC);
    do_rd(4'h3, "R7 sect unchanged");
    do_rd(4'h6, "R7 drvh unchanged");
    core_busy = 0;
    // R8
    do_wr(4'h7, 8'hC8);
    // R11
    do_wr(4'h1, 8'h77); do_wr(4'h9, 8'h66);
    do_rd(4'h1, "R11 unmapped read");
    do_rd(4'hF, "R11 unmapped read");
    chk_views();

    // R9 interrupt
    pulse_evt();
    do_rd(4'hE, "R9 alt keeps irq");
    chk("R9 alt no clear", irq, 1);
    do_rd(4'h7, "R9 status clears");
    chk("R9 cleared", irq, 0);
    pulse_evt();
    core_irq_evt = 1;
    do_rd(4'h7, "R9 set wins");
    chk("R9 set wins irq", irq, 1);
    // R10 mismatch
    do_wr(4'h6, 8'h10);
    chk("R10 mismatch", drv_match, 0);
    do_rd(4'h7, "R10 status zero");
    chk("R10 irq kept", irq, 1);
    do_rd(4'hE, "R10 alt zero");
    do_wr(4'h7, 8'h20);
    do_wr(4'h3, 8'hA5);
    do_rd(4'h3, "R10 taskfile still written");
    cfg_drive = 1;
    do_rd(4'h7, "R10 matched again clears");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [3:0] a;
      op = $urandom_range(0, 9);
      a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) a = 4'h7;
      core_busy  = ($urandom_range(0, 4) == 0);
      core_ready = 1'($urandom);
      core_flags = 6'($urandom);
      if (op == 9) cfg_drive = 1'($urandom);
      if (op < 4) do_wr(a, 8'($urandom));
      else if (op < 8) begin
        core_irq_evt = ($urandom_range(0, 3) == 0);
        do_rd(a, "R2/R6/R9/R11 random read");
      end else begin
        pulse_evt();
      end
      chk_views();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule